// File: doc/BRIEF.md
# Indexed Buffer Readout Window

This block gives a host a narrow window into a large event memory that is split into one buffer per channel. The host first writes a channel selector register. A write to the start-address register then works as a command: the block fetches a burst of consecutive 16-bit words from the selected channel's buffer, beginning at the written address, into a small staging file. The host then reads the burst back, word by word, through a single data register.

Fetching runs on a request channel to memory with valid/ready handshaking. A request stays on the bus, with its address unchanged, until the memory accepts it. The memory has no back-pressure on its response side: read data must appear exactly one cycle after each accepted request. Incoming words collect in a fill buffer. They become visible to the host only when the whole burst has arrived, so host reads made during a fetch still see the previous burst. Writing the channel selector aborts any fetch in flight and discards the staged words.

The host side is a plain register bus. `host_rdata` shows the addressed register combinationally. The data read pointer moves on the clock edge that ends a cycle in which `host_rd_en` is high. Register selects: 0 = channel selector, 1 = start address (write launches a fetch), 2 = data (read-only), 3 = status (read-only; bit 0 = busy, bit 1 = staged words valid, other bits zero).

Top module: `idx_rd_window`

## Requirements
- R1: After reset the status reads 0, the channel and start registers read 0, a data read returns 0, and `mem_req_valid` is low.
- R2: A write to select 1 sets busy from the next cycle. The block then requests the addresses {channel, start+i} for i = 0..BURST-1 in that order, with start+i wrapping inside the low-address width.
- R3: While `mem_req_valid` is high and `mem_req_ready` is low, the request and its address are held. Exactly BURST requests are accepted per completed fetch. Each response is taken from `mem_rdata` one cycle after its acceptance.
- R4: When the last word arrives, busy clears and valid sets. Data reads then return the words of the burst in address order. The pointer wraps to the first word after the BURST-th read.
- R5: While a fetch is running, data reads return the previously committed words and keep advancing through them.
- R6: A write to select 0 clears busy, drops `mem_req_valid` and clears valid in the next cycle. A fetch cancelled this way never commits.
- R7: While valid is 0, data reads return 0 and do not move the pointer.
- R8: Writes to selects 2 and 3 have no effect on any register, on the staged words or on the pointer.
- R9: A start write during a fetch restarts the fetch from the new address. Only the new burst is committed.
- R10: Status bit 0 is busy and bit 1 is valid. All other status bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_rd_en | input | 1 | Host register read strobe (advances data pointer) |
| host_addr | input | 2 | Register select |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Addressed register contents |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | CHAN_W+LADDR_W | Memory word address {channel, low} |
| mem_rdata | input | DATA_W | Read data, one cycle after acceptance |

## Verification
The bench builds the block with its defaults: 4 channel bits, 8 low-address bits and 16-bit words. Because the low address is only 8 bits wide, a start near 0xFC wraps inside the burst, which exercises R2's wrap rule in a few cycles. The bench also uses fixed ready-stall patterns, including a permanent stall. These cover request holding, a restart that lands mid-burst, and a cancellation before any word has arrived.

// File: rtl/idx_rd_pkg.sv
package idx_rd_pkg;
  typedef enum logic [1:0] {
    SEL_CHAN  = 2'd0,
    SEL_START = 2'd1,
    SEL_DATA  = 2'd2,
    SEL_STAT  = 2'd3
  } reg_sel_e;

  localparam int STAT_BUSY_BIT  = 0;
  localparam int STAT_VALID_BIT = 1;
endpackage

// File: rtl/idx_rd_fetch.sv
module idx_rd_fetch #(
  parameter int CHAN_W  = 4,
  parameter int LADDR_W = 8,
  parameter int DATA_W  = 16,
  parameter int BURST   = 8,
  localparam int CNT_W  = $clog2(BURST + 1),
  localparam int IDX_W  = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start_i,
  input  logic [LADDR_W-1:0]        base_i,
  input  logic [CHAN_W-1:0]         chan_i,
  input  logic                      cancel_i,
  output logic                      mem_req_valid_o,
  input  logic                      mem_req_ready_i,
  output logic [CHAN_W+LADDR_W-1:0] mem_req_addr_o,
  input  logic [DATA_W-1:0]         mem_rdata_i,
  output logic                      busy_o,
  output logic                      fill_we_o,
  output logic [IDX_W-1:0]          fill_idx_o,
  output logic [DATA_W-1:0]         fill_data_o,
  output logic                      done_o
);
  logic               busy_q;
  logic               rsp_q;
  logic [CNT_W-1:0]   issue_q;
  logic [CNT_W-1:0]   recv_q;
  logic [LADDR_W-1:0] next_q;
  logic               accept;
  logic               last_rsp;
  logic               hold_off;

  assign mem_req_valid_o = busy_q && (issue_q < CNT_W'(BURST));
  assign mem_req_addr_o  = {chan_i, next_q};
  assign accept          = mem_req_valid_o && mem_req_ready_i;
  assign last_rsp        = rsp_q && (recv_q == CNT_W'(BURST - 1));
  assign hold_off        = cancel_i || start_i;

  assign fill_we_o   = rsp_q && !hold_off;
  assign fill_idx_o  = recv_q[IDX_W-1:0];
  assign fill_data_o = mem_rdata_i;
  assign done_o      = last_rsp && !hold_off;
  assign busy_o      = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      rsp_q   <= 1'b0;
      issue_q <= '0;
      recv_q  <= '0;
      next_q  <= '0;
    end else if (cancel_i) begin
      busy_q  <= 1'b0;
      rsp_q   <= 1'b0;
      issue_q <= '0;
      recv_q  <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      rsp_q   <= 1'b0;
      issue_q <= '0;
      recv_q  <= '0;
      next_q  <= base_i;
    end else begin
      rsp_q <= accept;
      if (accept) begin
        issue_q <= issue_q + 1'b1;
        next_q  <= next_q + 1'b1;
      end
      if (rsp_q) begin
        recv_q <= recv_q + 1'b1;
        if (last_rsp) busy_q <= 1'b0;
      end
    end
  end

  // R3: a stalled request keeps its address until accepted
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i && !hold_off)
      |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  // R3: the response slot follows each acceptance by exactly one cycle
  assert_rsp_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !hold_off) |=> fill_we_o || cancel_i || start_i);

  // R6: cancellation empties the request channel
  assert_cancel_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_i |=> (!mem_req_valid_o && !busy_o));
endmodule

// File: rtl/idx_rd_stage.sv
module idx_rd_stage #(
  parameter int DATA_W = 16,
  parameter int BURST  = 8,
  localparam int IDX_W = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_we_i,
  input  logic [IDX_W-1:0]  fill_idx_i,
  input  logic [DATA_W-1:0] fill_data_i,
  input  logic              commit_i,
  input  logic              invalidate_i,
  input  logic              rd_adv_i,
  output logic [DATA_W-1:0] rd_word_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] vis_w [BURST];
  logic              valid_q;
  logic [IDX_W-1:0]  ptr_q;

  for (genvar i = 0; i < BURST; i++) begin : g_word
    logic [DATA_W-1:0] fill_q;
    logic [DATA_W-1:0] vis_q;
    logic              hit;
    assign hit = (fill_idx_i == IDX_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fill_q <= '0;
        vis_q  <= '0;
      end else begin
        if (fill_we_i && hit) fill_q <= fill_data_i;
        if (commit_i) vis_q <= hit ? fill_data_i : fill_q;
      end
    end
    assign vis_w[i] = vis_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      ptr_q   <= '0;
    end else if (commit_i) begin
      valid_q <= 1'b1;
      ptr_q   <= '0;
    end else if (invalidate_i) begin
      valid_q <= 1'b0;
      ptr_q   <= '0;
    end else if (rd_adv_i && valid_q) begin
      ptr_q <= (ptr_q == IDX_W'(BURST - 1)) ? '0 : ptr_q + 1'b1;
    end
  end

  assign rd_word_o = valid_q ? vis_w[ptr_q] : '0;
  assign valid_o   = valid_q;

  // R4: a commit makes the words valid and rewinds to the first one
  assert_commit_rewind_R4: assert property (@(posedge clk) disable iff (!rst_n)
    commit_i |=> (valid_o && ptr_q == '0));

  // R7: reads of an invalid file leave the pointer alone
  assert_invalid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_q && !commit_i) |=> $stable(ptr_q));
endmodule

// File: rtl/idx_rd_window.sv
module idx_rd_window
  import idx_rd_pkg::*;
#(
  parameter int CHAN_W  = 4,
  parameter int LADDR_W = 8,
  parameter int DATA_W  = 16,
  parameter int BURST   = 8,
  localparam int MEM_AW = CHAN_W + LADDR_W,
  localparam int IDX_W  = (BURST > 1) ? $clog2(BURST) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr_en,
  input  logic              host_rd_en,
  input  logic [1:0]        host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [MEM_AW-1:0] mem_req_addr,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [CHAN_W-1:0]  chan_q;
  logic [LADDR_W-1:0] low_q;
  logic               wr_chan, wr_start, rd_data;
  logic               busy_s, valid_s;
  logic               fill_we, done;
  logic [IDX_W-1:0]   fill_idx;
  logic [DATA_W-1:0]  fill_data, rd_word;
  reg_sel_e           sel;

  assign sel      = reg_sel_e'(host_addr);
  assign wr_chan  = host_wr_en && (sel == SEL_CHAN);
  assign wr_start = host_wr_en && (sel == SEL_START);
  assign rd_data  = host_rd_en && (sel == SEL_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      low_q  <= '0;
    end else begin
      if (wr_chan)  chan_q <= host_wdata[CHAN_W-1:0];
      if (wr_start) low_q  <= host_wdata[LADDR_W-1:0];
    end
  end

  idx_rd_fetch #(
    .CHAN_W(CHAN_W), .LADDR_W(LADDR_W), .DATA_W(DATA_W), .BURST(BURST)
  ) u_fetch (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (wr_start),
    .base_i         (host_wdata[LADDR_W-1:0]),
    .chan_i         (chan_q),
    .cancel_i       (wr_chan),
    .mem_req_valid_o(mem_req_valid),
    .mem_req_ready_i(mem_req_ready),
    .mem_req_addr_o (mem_req_addr),
    .mem_rdata_i    (mem_rdata),
    .busy_o         (busy_s),
    .fill_we_o      (fill_we),
    .fill_idx_o     (fill_idx),
    .fill_data_o    (fill_data),
    .done_o         (done)
  );

  idx_rd_stage #(
    .DATA_W(DATA_W), .BURST(BURST)
  ) u_stage (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill_we_i   (fill_we),
    .fill_idx_i  (fill_idx),
    .fill_data_i (fill_data),
    .commit_i    (done),
    .invalidate_i(wr_chan),
    .rd_adv_i    (rd_data),
    .rd_word_o   (rd_word),
    .valid_o     (valid_s)
  );

  always_comb begin
    host_rdata = '0;
    unique case (sel)
      SEL_CHAN:  host_rdata = DATA_W'(chan_q);
      SEL_START: host_rdata = DATA_W'(low_q);
      SEL_DATA:  host_rdata = rd_word;
      SEL_STAT: begin
        host_rdata[STAT_BUSY_BIT]  = busy_s;
        host_rdata[STAT_VALID_BIT] = valid_s;
      end
      default:   host_rdata = '0;
    endcase
  end

  // R2: a start write makes the block busy on the next cycle
  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> busy_s);

  // R6: a channel write drops the staged words
  assert_chan_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_chan |=> (!valid_s && !busy_s));

  // R8: writes to the read-only selects change no register
  assert_ro_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr_en && (sel == SEL_DATA || sel == SEL_STAT))
      |=> ($stable(chan_q) && $stable(low_q)));
endmodule

// File: tb/idx_rd_window_test.sv
module idx_rd_window_test;
  localparam int CLK_NS = 20;
  localparam int NV = 5;
  localparam logic [3:0] T_CHAN  [NV] = '{4'h1, 4'h7, 4'hF, 4'h0, 4'h3};
  localparam logic [7:0] T_LOW   [NV] = '{8'h00, 8'h10, 8'hFC, 8'hF8, 8'h5A};
  localparam logic [7:0] T_STALL [NV] = '{8'h00, 8'h55, 8'h0F, 8'h81, 8'hEE};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_en = 1'b0, host_rd_en = 1'b0;
  logic [1:0]  host_addr = '0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [11:0] mem_req_addr;
  logic [15:0] mem_rdata = '0;

  int checks = 0, errors = 0;
  logic [7:0] stall_pat = 8'h00;
  logic [2:0] cyc = '0;
  logic       addr_chk = 1'b0;
  logic [3:0] exp_chan = '0;
  logic [7:0] exp_low = '0;
  int         acc_idx = 0;

  idx_rd_window uut (
    .clk(clk), .rst_n(rst_n), .host_wr_en(host_wr_en), .host_rd_en(host_rd_en),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rdata(mem_rdata)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [15:0] model(input logic [11:0] a);
    return {a[3:0], a} ^ 16'h5A3C;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    mem_req_ready = !stall_pat[cyc];
    cyc = cyc + 1'b1;
  end

  always @(posedge clk) begin
    if (mem_req_valid && mem_req_ready) begin
      mem_rdata <= model(mem_req_addr);
      if (addr_chk) begin
        chk("R2 request address", {4'h0, mem_req_addr},
            {4'h0, exp_chan, 8'(exp_low + 8'(acc_idx))});
      end
      acc_idx = acc_idx + 1;
    end
  end

  task automatic host_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    host_rd_en = 1'b1; host_addr = a;
    #1 d = host_rdata;
    @(negedge clk);
    host_rd_en = 1'b0;
  endtask

  task automatic start_burst(input logic [3:0] c, input logic [7:0] l);
    exp_chan = c; exp_low = l; acc_idx = 0;
    host_write(2'd1, {8'h00, l});
  endtask

  task automatic wait_idle(input string req);
    logic [15:0] s;
    s = 16'h0001;
    for (int n = 0; n < 200 && s[0]; n++) host_read(2'd3, s);
    chk(req, s, 16'h0002);
  endtask

  initial begin
    #(CLK_NS * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    host_read(2'd3, d); chk("R1 status", d, 16'h0000);
    host_read(2'd0, d); chk("R1 channel", d, 16'h0000);
    host_read(2'd1, d); chk("R1 start", d, 16'h0000);
    chk("R1 mem_req_valid", {15'h0, mem_req_valid}, 16'h0000);
    // R7 invalid data reads
    host_read(2'd2, d); chk("R7 data while invalid", d, 16'h0000);

    // vector walk: R2 R3 R4 R10
    addr_chk = 1'b1;
    for (int v = 0; v < NV; v++) begin
      stall_pat = T_STALL[v];
      host_write(2'd0, {12'h000, T_CHAN[v]});
      start_burst(T_CHAN[v], T_LOW[v]);
      host_read(2'd3, d); chk("R2 busy after start", {15'h0, d[0]}, 16'h0001);
      wait_idle("R10 status after commit");
      chk("R3 accepted count", 16'(acc_idx), 16'd8);
      for (int i = 0; i < 8; i++) begin
        host_read(2'd2, d);
        chk("R4 burst word", d, model({T_CHAN[v], 8'(T_LOW[v] + 8'(i))}));
      end
      host_read(2'd2, d);
      chk("R4 pointer wrap", d, model({T_CHAN[v], T_LOW[v]}));
    end

    // R5 reads during fetch see old words
    stall_pat = 8'h00;
    host_write(2'd0, 16'h0002);
    start_burst(4'h2, 8'h20);
    wait_idle("R4 commit before R5");
    stall_pat = 8'hFF;
    start_burst(4'h2, 8'h40);
    host_read(2'd2, d); chk("R5 old word 0", d, model({4'h2, 8'h20}));
    host_read(2'd2, d); chk("R5 old word 1", d, model({4'h2, 8'h21}));
    stall_pat = 8'h00;
    wait_idle("R5 new commit");
    host_read(2'd2, d); chk("R5 new word 0", d, model({4'h2, 8'h40}));

    // R8 writes to read-only selects
    host_write(2'd2, 16'hFFFF);
    host_write(2'd3, 16'hFFFF);
    host_read(2'd3, d); chk("R8 status unchanged", d, 16'h0002);
    host_read(2'd0, d); chk("R8 channel unchanged", d, 16'h0002);
    host_read(2'd1, d); chk("R8 start unchanged", d, 16'h0040);
    host_read(2'd2, d); chk("R8 pointer unchanged", d, model({4'h2, 8'h41}));

    // R6 cancel by channel write
    stall_pat = 8'hFF;
    start_burst(4'h2, 8'h80);
    host_write(2'd0, 16'h0009);
    chk("R6 request dropped", {15'h0, mem_req_valid}, 16'h0000);
    host_read(2'd3, d); chk("R6 status cleared", d, 16'h0000);
    host_read(2'd2, d); chk("R6 data zero", d, 16'h0000);
    stall_pat = 8'h00;
    repeat (20) @(negedge clk);
    host_read(2'd3, d); chk("R6 no late commit", d, 16'h0000);
    host_read(2'd2, d); chk("R7 data still zero", d, 16'h0000);

    // R9 restart mid-burst
    addr_chk = 1'b0;
    stall_pat = 8'hAA;
    start_burst(4'h9, 8'h30);
    repeat (4) @(negedge clk);
    start_burst(4'h9, 8'hC0);
    wait_idle("R9 restart commit");
    for (int i = 0; i < 8; i++) begin
      host_read(2'd2, d);
      chk("R9 new burst word", d, model({4'h9, 8'(8'hC0 + 8'(i))}));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule